// File: doc/BRIEF.md
# Configuration shadow mismatch monitor

This block holds a small bank of pin-mapping control registers and keeps a second, hidden copy of each one. A legal write on the register port loads the visible (primary) copy and the hidden copy on the same clock edge. On every cycle the block compares the two banks. If they disagree and no legal write caused it, for example after a storage upset, the block sends a device reset request to the reset sequencer.

The primary copy drives the mapping outputs and the read port. A fault-injection input flips selected bits of one primary register and leaves the hidden copy alone, so a test can show that corruption is caught. A reset request lasts one cycle. With it comes a cause vector in which bit 9 marks a configuration mismatch. Bit 9 is kept because the reset status register downstream decodes the mismatch flag at that position.

Top module: `cfg_shadow_guard`

## Requirements
- R1: After synchronous reset every register on `map_out` holds `RST_VAL` (default 8'hA5), and `rst_req` and `rst_cause` are zero.
- R2: A write with `wr_en` high loads `wr_data` into register `wr_addr`, which appears on `map_out` (register i at bits i*DATA_W upward) after that edge. A write never raises `rst_req`.
- R3: `rd_data` shows the primary copy of register `rd_addr` as it stood before the previous clock edge (one cycle of latency).
- R4: When `inj_en` is high, the edge XORs `inj_mask` into the primary copy of register `inj_addr` only. If this leaves the copies different, `rst_req` goes high in the cycle after the following edge.
- R5: `rst_cause` is zero except while `rst_req` is high. In that cycle it is 16 bits with only bit 9 set.
- R6: `rst_req` is a single-cycle pulse. A disagreement that persists, or further corruption while the copies already differ, gives no further pulse.
- R7: A legal write to a corrupted register restores agreement. A later corruption raises a new pulse.
- R8: An injection with an all-zero mask changes no register and raises no request.
- R9: If a write and an injection hit the same register in the same cycle, the primary takes `wr_data ^ inj_mask` and the hidden copy takes `wr_data`, so a request follows.
- R10: Corruption in any one of the registers is detected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Legal register write strobe |
| wr_addr | input | ADDR_W | Register index for the write |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Register index for the read |
| rd_data | output | DATA_W | Registered read data (primary copy) |
| inj_en | input | 1 | Test fault-injection strobe |
| inj_addr | input | ADDR_W | Register index to corrupt |
| inj_mask | input | DATA_W | Bits to flip in the primary copy |
| map_out | output | NUM_REGS*DATA_W | Primary register contents for the pin mapper |
| rst_req | output | 1 | One-cycle device reset request |
| rst_cause | output | 16 | Reset cause vector, bit 9 = configuration mismatch |

## Verification
The bench aims at the cases a faulty design would get wrong in ways that are easy to see:
- A write that updated only one copy would turn every legal write into a spurious reset.
- A level instead of a pulse would hold the request high for as long as the corruption stays.
- A missing edge detector would fire again on a second flip.
- Injection that reached the hidden copy, or a write that won over a same-cycle injection, would hide a real fault.

It also corrupts each register in turn, to catch a comparator that covers only part of the bank. It checks that a repaired register re-arms detection, and that an all-zero mask is harmless.

// File: rtl/cfg_shadow_pkg.sv
package cfg_shadow_pkg;
  localparam int CAUSE_W      = 16;
  localparam int MISMATCH_BIT = 9;   // decoded by the reset status register
endpackage

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank #(
  parameter int          N       = 4,
  parameter int          W       = 8,
  parameter int          AW      = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [AW-1:0]  wr_addr,
  input  logic [W-1:0]   wr_data,
  input  logic           flip_en,
  input  logic [AW-1:0]  flip_addr,
  input  logic [W-1:0]   flip_mask,
  output logic [N*W-1:0] q_flat
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [W-1:0] cur_q;
    logic [W-1:0] nxt;

    always_comb begin
      nxt = cur_q;
      if (wr_en && (wr_addr == AW'(i)))
        nxt = wr_data;
      if (flip_en && (flip_addr == AW'(i)))
        nxt = nxt ^ flip_mask;
    end

    always_ff @(posedge clk) begin
      if (rst) cur_q <= RST_VAL;
      else     cur_q <= nxt;
    end

    assign q_flat[i*W +: W] = cur_q;
  end
endmodule

// File: rtl/cfg_mismatch_detect.sv
module cfg_mismatch_detect
  import cfg_shadow_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N*W-1:0]     a_flat,
  input  logic [N*W-1:0]     b_flat,
  output logic               req,
  output logic [CAUSE_W-1:0] cause
);
  localparam logic [CAUSE_W-1:0] CAUSE_CODE = CAUSE_W'(1) << MISMATCH_BIT;

  logic [N-1:0] reg_diff;
  logic         diff_any;
  logic         mm_q;

  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign reg_diff[i] = |(a_flat[i*W +: W] ^ b_flat[i*W +: W]);
  end
  assign diff_any = |reg_diff;

  always_ff @(posedge clk) begin
    if (rst) begin
      mm_q  <= 1'b0;
      req   <= 1'b0;
      cause <= '0;
    end else begin
      mm_q  <= diff_any;
      req   <= diff_any & ~mm_q;
      cause <= (diff_any & ~mm_q) ? CAUSE_CODE : '0;
    end
  end
endmodule

// File: rtl/cfg_shadow_guard.sv
module cfg_shadow_guard
  import cfg_shadow_pkg::*;
#(
  parameter int                NUM_REGS = 4,
  parameter int                DATA_W   = 8,
  parameter logic [DATA_W-1:0] RST_VAL  = 8'hA5,
  localparam int               ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic [DATA_W-1:0]          rd_data,
  input  logic                       inj_en,
  input  logic [ADDR_W-1:0]          inj_addr,
  input  logic [DATA_W-1:0]          inj_mask,
  output logic [NUM_REGS*DATA_W-1:0] map_out,
  output logic                       rst_req,
  output logic [CAUSE_W-1:0]         rst_cause
);
  localparam int RD_SLOTS = 2 ** ADDR_W;

  logic [NUM_REGS*DATA_W-1:0] prim_flat;
  logic [NUM_REGS*DATA_W-1:0] shad_flat;
  logic [DATA_W-1:0]          rd_mux [RD_SLOTS];

  cfg_reg_bank #(.N(NUM_REGS), .W(DATA_W), .AW(ADDR_W), .RST_VAL(RST_VAL)) u_primary (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flip_en   (inj_en),
    .flip_addr (inj_addr),
    .flip_mask (inj_mask),
    .q_flat    (prim_flat)
  );

  cfg_reg_bank #(.N(NUM_REGS), .W(DATA_W), .AW(ADDR_W), .RST_VAL(RST_VAL)) u_shadow (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .flip_en   (1'b0),
    .flip_addr ({ADDR_W{1'b0}}),
    .flip_mask ({DATA_W{1'b0}}),
    .q_flat    (shad_flat)
  );

  cfg_mismatch_detect #(.N(NUM_REGS), .W(DATA_W)) u_detect (
    .clk    (clk),
    .rst    (rst),
    .a_flat (prim_flat),
    .b_flat (shad_flat),
    .req    (rst_req),
    .cause  (rst_cause)
  );

  for (genvar s = 0; s < RD_SLOTS; s++) begin : g_rd
    if (s < NUM_REGS) begin : g_live
      assign rd_mux[s] = prim_flat[s*DATA_W +: DATA_W];
    end else begin : g_pad
      assign rd_mux[s] = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux[rd_addr];
  end

  assign map_out = prim_flat;
endmodule

// File: rtl/cfg_shadow_guard_chk.sv
module cfg_shadow_guard_chk
  import cfg_shadow_pkg::*;
#(
  parameter int           N       = 4,
  parameter int           W       = 8,
  parameter int           AW      = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input logic               clk,
  input logic               rst,
  input logic               wr_en,
  input logic [AW-1:0]      wr_addr,
  input logic [W-1:0]       wr_data,
  input logic               inj_en,
  input logic [N*W-1:0]     map_out,
  input logic [N*W-1:0]     prim_flat,
  input logic [N*W-1:0]     shad_flat,
  input logic               rst_req,
  input logic [CAUSE_W-1:0] rst_cause
);
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (map_out == {N{RST_VAL}}) && !rst_req && (rst_cause == '0)); // R1

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !inj_en) |=> (map_out[$past(wr_addr)*W +: W] == $past(wr_data))); // R2

  AST_REQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
    rst_req |-> (rst_cause[MISMATCH_BIT] && ($countones(rst_cause) == 1))); // R5

  AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rst_req |-> (rst_cause == '0)); // R5

  AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req); // R6

  AST_REQ_FROM_DIFF: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_req) |-> ($past(prim_flat) != $past(shad_flat))); // R4
endmodule

bind cfg_shadow_guard cfg_shadow_guard_chk #(
  .N(NUM_REGS), .W(DATA_W), .AW(ADDR_W), .RST_VAL(RST_VAL)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .inj_en    (inj_en),
  .map_out   (map_out),
  .prim_flat (prim_flat),
  .shad_flat (shad_flat),
  .rst_req   (rst_req),
  .rst_cause (rst_cause)
);

// File: tb/test_cfg_shadow_guard.sv
`timescale 1ns/100ps
module test_cfg_shadow_guard;
  localparam int N  = 4;
  localparam int W  = 8;
  localparam int AW = 2;
  localparam logic [W-1:0] RV = 8'hA5;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [AW-1:0]  wr_addr = '0;
  logic [W-1:0]   wr_data = '0;
  logic [AW-1:0]  rd_addr = '0;
  logic [W-1:0]   rd_data;
  logic           inj_en = 1'b0;
  logic [AW-1:0]  inj_addr = '0;
  logic [W-1:0]   inj_mask = '0;
  logic [N*W-1:0] map_out;
  logic           rst_req;
  logic [15:0]    rst_cause;

  int n_checks = 0;
  int n_fail   = 0;
  int pulses   = 0;
  bit done     = 0;

  // reference model state
  int  m_prim [N];
  int  m_shad [N];
  bit  m_mm;
  bit  m_req;
  int  m_rd;
  bit  m_valid = 0;

  logic [W-1:0] orig [N];

  always #2.5 clk = ~clk;

  cfg_shadow_guard i_cfg_shadow_guard (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .inj_en(inj_en), .inj_addr(inj_addr),
    .inj_mask(inj_mask), .map_out(map_out), .rst_req(rst_req), .rst_cause(rst_cause)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_prim[i] = RV; m_shad[i] = RV; end
      m_mm = 0; m_req = 0; m_rd = 0;
    end else begin
      bit differ;
      differ = 0;
      m_rd = m_prim[rd_addr];
      for (int i = 0; i < N; i++) if (m_prim[i] != m_shad[i]) differ = 1;
      m_req = differ && !m_mm;
      m_mm  = differ;
      if (wr_en) begin m_prim[wr_addr] = wr_data; m_shad[wr_addr] = wr_data; end
      if (inj_en) m_prim[inj_addr] = m_prim[inj_addr] ^ inj_mask;
    end
    m_valid = 1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (m_valid && !done) begin
      for (int i = 0; i < N; i++)
        chk("R2 map register", map_out[i*W +: W], m_prim[i]);
      chk("R3 read data", rd_data, m_rd);
      chk("R4 reset request", rst_req, m_req);
      chk("R5 cause vector", rst_cause, m_req ? 16'h0200 : 16'h0000);
      if (rst_req) pulses++;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_write(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic do_inject(input int a, input logic [W-1:0] m);
    @(negedge clk);
    inj_en = 1; inj_addr = AW'(a); inj_mask = m;
    @(negedge clk);
    inj_en = 0; inj_mask = '0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    int base;
    orig[0] = 8'h3C; orig[1] = 8'hC3; orig[2] = 8'h5A; orig[3] = 8'h0F;
    repeat (3) @(negedge clk);
    rst = 0;
    idle(2);
    // R1: defaults after reset
    chk("R1 map after reset", map_out, {N{RV}});
    chk("R1 request after reset", rst_req, 0);
    chk("R1 cause after reset", rst_cause, 0);

    // R2: legal writes, no request
    for (int i = 0; i < N; i++) do_write(i, orig[i]);
    idle(3);
    chk("R2 written bank", map_out, {orig[3], orig[2], orig[1], orig[0]});
    chk("R2 no request from writes", pulses, 0);

    // R3: read port
    rd_addr = 2;
    idle(2);
    chk("R3 read reg2", rd_data, 8'h5A);

    // R4 and R6: corruption, single pulse
    do_inject(2, 8'h10);
    idle(4);
    chk("R4 one request", pulses, 1);
    chk("R4 primary flipped", map_out[2*W +: W], 8'h4A);
    do_inject(1, 8'h01);
    idle(4);
    chk("R6 no second pulse", pulses, 1);

    // R7: repair re-arms detection
    do_write(2, orig[2]);
    do_write(1, orig[1]);
    idle(3);
    chk("R7 repair quiet", pulses, 1);
    do_inject(0, 8'h80);
    idle(4);
    chk("R7 new pulse after repair", pulses, 2);
    do_write(0, orig[0]);
    idle(3);

    // R8: zero mask is harmless
    do_inject(3, 8'h00);
    idle(4);
    chk("R8 zero mask no pulse", pulses, 2);
    chk("R8 zero mask no change", map_out[3*W +: W], orig[3]);

    // R9: write and injection on the same register together
    @(negedge clk);
    wr_en = 1; wr_addr = 3; wr_data = 8'h77;
    inj_en = 1; inj_addr = 3; inj_mask = 8'h02;
    @(negedge clk);
    wr_en = 0; inj_en = 0; inj_mask = '0;
    idle(4);
    chk("R9 primary takes data^mask", map_out[3*W +: W], 8'h75);
    chk("R9 request raised", pulses, 3);
    orig[3] = 8'h77;
    do_write(3, orig[3]);
    idle(3);

    // R10: every register is covered
    for (int i = 0; i < N; i++) begin
      base = pulses;
      do_inject(i, W'(1) << i);
      idle(4);
      chk("R10 per-register detection", pulses, base + 1);
      do_write(i, orig[i]);
      idle(3);
    end

    finish_run();
  end
endmodule